// File: doc/BRIEF.md
# Flash Programming Mode Controller

This block is the parallel-programming front end of an on-chip code flash array. A programming station sets a group of mode pins to static levels and pulses a programming strobe. The block reads those levels as one operation: byte write, byte verify read, one of three lock-bit writes, chip erase or a signature read. It drives the array's write and erase strobes and returns read data on an 8-bit output.

A byte write starts on a single strobe pulse and then finishes on an internal cycle counter. While the write runs, a ready output is low. A verify read of the byte in flight returns its top bit inverted, so software can poll for completion. Chip erase needs the strobe held low for a set number of cycles. It also clears the lock bits. The lock bits gate further programming and verify reads. They cannot be read back.

The flash array sits outside the block. It has a combinational read port and a write port that acts on a strobe. The write and erase durations are given in clock cycles.

Top module: `flash_prog_ctrl`

## Requirements
- R1: An operation is decoded only while `prog_mode` is 1 and `psen_n` is 0. `mode_sel` bits 3..0 select the operation: 0111 = byte write, 0011 = verify read, 1000 = chip erase, 0000 = signature read, 1111 = lock 1, 1100 = lock 2, 1010 = lock 3. A byte write starts on a 0-to-1 transition of `prog_n` and latches `addr` and `din`. The byte is stored WR_CYCLES cycles later with no further strobe.
- R2: After reset, `ready` is 1 and `dout` is 00h. Once a write-type operation is accepted, `ready` is 0 for exactly WR_CYCLES cycles, starting with the cycle after the clock edge that samples the strobe's rising transition, and is then 1 again.
- R3: During a byte write, a verify read of the address being written returns the complement of bit 7 of the written byte on `dout[7]` and the array's current bits 6..0. After completion it returns the true byte.
- R4: A strobe transition that arrives while `ready` is 0 is ignored. Its address and data are never written.
- R5: A byte write to a location that does not read FFh is rejected. There is no busy period and the location is unchanged.
- R6: Every write-type operation (byte write, lock writes, erase) needs `hv_ok` = 1. Without it the operation has no effect.
- R7: Chip erase happens when `prog_n` is sampled low on ERASE_CYCLES consecutive edges with the erase selection and `hv_ok`. The erase sets every byte to FFh and clears both lock bits. It fires once for each hold. A shorter hold has no effect.
- R8: A signature read returns 1Eh at address 30h, 62h at 31h, FFh at 32h and 00h at any other address.
- R9: Once lock 1 is programmed, byte writes are refused.
- R10: With lock 1 and lock 2 both programmed, verify reads return 00h. Lock 2 alone does not block them. A lock 3 write runs a timed busy period with no visible effect on this block.
- R11: Outside programming mode (`prog_mode` = 0 or `psen_n` = 1), `dout` is 00h and no operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Programming mode entry level |
| psen_n | input | 1 | Must be low for programming operations |
| prog_n | input | 1 | Programming strobe, active low |
| hv_ok | input | 1 | Programming voltage present |
| mode_sel | input | 4 | Operation select levels |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data |
| ready | output | 1 | 1 = idle, 0 = timed write in progress |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array read data |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array byte write strobe |
| arr_erase | output | 1 | Array full erase strobe |

## Verification
The bench builds the block with ADDR_W = 6, WR_CYCLES = 5 and ERASE_CYCLES = 12. A 64-byte array still holds all three signature addresses. With these values, busy windows, write polling and the erase boundary (an 11-cycle hold versus a 12-cycle hold) each take a few dozen cycles. A behavioural model follows locks, the in-flight write and the array contents, and is compared with `dout` and `ready` on every cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_CODE,
    OP_WR_CODE,
    OP_WR_LK1,
    OP_WR_LK2,
    OP_WR_LK3,
    OP_ERASE,
    OP_RD_SIG
  } fpm_op_e;

  // Pin-level decode; select bit order is significant.
  function automatic fpm_op_e decode_op(input logic en, input logic psen_n,
                                        input logic [3:0] sel);
    if (!en || psen_n) return OP_NONE;
    case (sel)
      4'b0111: return OP_WR_CODE;
      4'b0011: return OP_RD_CODE;
      4'b1000: return OP_ERASE;
      4'b0000: return OP_RD_SIG;
      4'b1111: return OP_WR_LK1;
      4'b1100: return OP_WR_LK2;
      4'b1010: return OP_WR_LK3;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic is_write_type(input fpm_op_e op);
    return (op == OP_WR_CODE) || (op == OP_WR_LK1) ||
           (op == OP_WR_LK2) || (op == OP_WR_LK3);
  endfunction

  function automatic logic [7:0] sig_byte(input logic [15:0] a);
    case (a)
      16'h0030: return 8'h1E;
      16'h0031: return 8'h62;
      16'h0032: return 8'hFF;
      default:  return 8'h00;
    endcase
  endfunction

  // Polling value: inverted top bit of the byte in flight.
  function automatic logic [7:0] poll_byte(input logic [7:0] pending,
                                           input logic [7:0] cur);
    return {~pending[7], cur[6:0]};
  endfunction

endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
  import fpm_pkg::*;
(
  input  logic       prog_mode,
  input  logic       psen_n,
  input  logic [3:0] mode_sel,
  output fpm_op_e    op
);
  assign op = decode_op(prog_mode, psen_n, mode_sel);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int WR_CYCLES    = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpm_op_e           op,
  input  logic              prog_n,
  input  logic              hv_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [7:0]        cur_byte,
  output logic              busy,
  output logic              code_pending,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [7:0]        pend_data,
  output logic              wr_lock,
  output logic              rd_lock,
  output logic              mem_we,
  output logic              mem_erase
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam int EW = $clog2(ERASE_CYCLES + 1);

  logic          prog_q;
  logic [CW-1:0] cnt;
  logic [EW-1:0] ecnt;
  fpm_op_e       pend_op;
  logic          lk1, lk2;

  // Named internal events
  logic strobe_rise, accept, busy_req, wr_done, erase_cond, erase_fire;

  assign strobe_rise = !prog_q && prog_n;
  assign busy_req    = busy && strobe_rise;
  assign accept      = !busy && strobe_rise && hv_ok && is_write_type(op) &&
                       (op != OP_WR_CODE || (!lk1 && cur_byte == 8'hFF));
  assign wr_done     = busy && (cnt == '0);
  assign erase_cond  = !busy && (op == OP_ERASE) && hv_ok && !prog_n;
  assign erase_fire  = erase_cond && (ecnt == EW'(ERASE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= 1'b1;
    else        prog_q <= prog_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pend_op   <= OP_NONE;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt       <= CW'(WR_CYCLES - 1);
      pend_op   <= op;
      pend_addr <= addr;
      pend_data <= din;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk1 <= 1'b0;
      lk2 <= 1'b0;
    end else if (erase_fire) begin
      lk1 <= 1'b0;
      lk2 <= 1'b0;
    end else if (wr_done) begin
      if (pend_op == OP_WR_LK1) lk1 <= 1'b1;
      if (pend_op == OP_WR_LK2) lk2 <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ecnt <= '0;
    else if (!erase_cond)                         ecnt <= '0;
    else if (ecnt != EW'(ERASE_CYCLES))           ecnt <= ecnt + 1'b1;
  end

  assign code_pending = busy && (pend_op == OP_WR_CODE);
  assign mem_we       = wr_done && (pend_op == OP_WR_CODE);
  assign mem_erase    = erase_fire;
  assign wr_lock      = lk1;
  assign rd_lock      = lk1 && lk2;

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R2
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_req |=> ($stable(pend_addr) && $stable(pend_data))); // R4
  AST_NO_HV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_ok && !busy) |=> !busy); // R6
  AST_ERASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |=> !mem_erase); // R7
  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |=> (!lk1 && !lk2)); // R7
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !lk1); // R9

endmodule

// File: rtl/fpm_readout.sv
module fpm_readout
  import fpm_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  fpm_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cur_byte,
  input  logic              code_pending,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [7:0]        pend_data,
  input  logic              rd_lock,
  output logic [7:0]        dout
);
  always_comb begin
    dout = 8'h00;
    case (op)
      OP_RD_CODE: begin
        if (rd_lock)                                dout = 8'h00;
        else if (code_pending && addr == pend_addr) dout = poll_byte(pend_data, cur_byte);
        else                                        dout = cur_byte;
      end
      OP_RD_SIG: dout = sig_byte(16'(addr));
      default:   dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int WR_CYCLES    = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              psen_n,
  input  logic              prog_n,
  input  logic              hv_ok,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_erase
);
  fpm_op_e           op;
  logic              busy, code_pending, wr_lock, rd_lock;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data;

  fpm_decode u_dec (
    .prog_mode(prog_mode), .psen_n(psen_n), .mode_sel(mode_sel), .op(op)
  );

  fpm_seq #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .prog_n(prog_n), .hv_ok(hv_ok),
    .addr(addr), .din(din), .cur_byte(arr_rdata), .busy(busy),
    .code_pending(code_pending), .pend_addr(pend_addr), .pend_data(pend_data),
    .wr_lock(wr_lock), .rd_lock(rd_lock), .mem_we(arr_we), .mem_erase(arr_erase)
  );

  fpm_readout #(.ADDR_W(ADDR_W)) u_rd (
    .op(op), .addr(addr), .cur_byte(arr_rdata), .code_pending(code_pending),
    .pend_addr(pend_addr), .pend_data(pend_data), .rd_lock(rd_lock), .dout(dout)
  );

  assign ready     = !busy;
  assign arr_raddr = addr;
  assign arr_waddr = pend_addr;
  assign arr_wdata = pend_data;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_we, arr_erase})); // R7
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> ready); // R2
  AST_POLL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_pending && op == OP_RD_CODE && addr == pend_addr && !rd_lock)
      |-> (dout[7] != pend_data[7])); // R3
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && op == OP_RD_CODE) |-> (dout == 8'h00)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode || psen_n) |-> (dout == 8'h00)); // R11

  wire unused_ok = wr_lock;

endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int CLK   = 10;
  localparam int AW    = 6;
  localparam int WR    = 5;
  localparam int ER    = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic prog_mode = 0, psen_n = 1, prog_n = 1, hv_ok = 0;
  logic [3:0] mode_sel = 4'b0000;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, arr_rdata, arr_wdata;
  logic ready, arr_we, arr_erase;
  logic [AW-1:0] arr_raddr, arr_waddr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WR_CYCLES(WR), .ERASE_CYCLES(ER)) uut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .psen_n(psen_n),
    .prog_n(prog_n), .hv_ok(hv_ok), .mode_sel(mode_sel), .addr(addr), .din(din),
    .dout(dout), .ready(ready), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_erase(arr_erase)
  );

  // Behavioural flash array attached to the block
  logic [7:0] arr [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) arr[i] = 8'hFF;
  always @(posedge clk) begin
    if (arr_erase) for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
    else if (arr_we) arr[arr_waddr] <= arr_wdata;
  end
  assign arr_rdata = arr[arr_raddr];

  // Reference model
  logic [7:0] mmem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) mmem[i] = 8'hFF;
  bit m_busy, m_prev, m_l1, m_l2;
  int m_cnt, m_ecnt, m_kind;
  logic [AW-1:0] m_addr;
  logic [7:0] m_data;

  // 0 none,1 read,2 write,3 lock1,4 lock2,5 lock3,6 erase,7 signature
  function automatic int bop();
    if (prog_mode !== 1'b1 || psen_n !== 1'b0) return 0;
    if (mode_sel == 4'b0011) return 1;
    if (mode_sel == 4'b0111) return 2;
    if (mode_sel == 4'b1111) return 3;
    if (mode_sel == 4'b1100) return 4;
    if (mode_sel == 4'b1010) return 5;
    if (mode_sel == 4'b1000) return 6;
    if (mode_sel == 4'b0000) return 7;
    return 0;
  endfunction

  function automatic logic [7:0] exp_dout();
    int op = bop();
    if (op == 1) begin
      if (m_l1 && m_l2) return 8'h00;
      if (m_busy && m_kind == 2 && addr == m_addr) return {~m_data[7], mmem[addr][6:0]};
      return mmem[addr];
    end
    if (op == 7) begin
      if (addr == 6'd48) return 8'h1E;
      if (addr == 6'd49) return 8'h62;
      if (addr == 6'd50) return 8'hFF;
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 1; m_l1 = 0; m_l2 = 0; m_cnt = 0; m_ecnt = 0; m_kind = 0;
    end else begin
      int op;
      bit was_busy, rise;
      op = bop();
      was_busy = m_busy;
      rise = (m_prev == 0) && (prog_n == 1);
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_kind == 2) mmem[m_addr] = m_data;
          if (m_kind == 3) m_l1 = 1;
          if (m_kind == 4) m_l2 = 1;
        end else m_cnt--;
      end else if (rise && hv_ok && op >= 2 && op <= 5) begin
        if (op != 2 || (!m_l1 && mmem[addr] == 8'hFF)) begin
          m_busy = 1; m_cnt = WR - 1; m_kind = op; m_addr = addr; m_data = din;
        end
      end
      if (!was_busy && op == 6 && hv_ok && !prog_n) begin
        if (m_ecnt < ER) begin
          m_ecnt++;
          if (m_ecnt == ER) begin
            for (int i = 0; i < DEPTH; i++) mmem[i] = 8'hFF;
            m_l1 = 0; m_l2 = 0;
          end
        end
      end else m_ecnt = 0;
      m_prev = prog_n;
    end
  end

  // Per-cycle comparison, three quarters into the cycle
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      checks++;
      if (dout !== exp_dout() || ready !== !m_busy) begin
        fails++;
        $display("FAIL R1 R2 R3 model t=%0t dout=%h ready=%b expected dout=%h ready=%b",
                 $time, dout, ready, exp_dout(), !m_busy);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_at(input logic [3:0] sel, input logic [AW-1:0] a);
    tick(); mode_sel = sel; addr = a; #2;
  endtask

  task automatic pulse(input logic [3:0] sel, input logic [AW-1:0] a, input logic [7:0] d);
    tick(); mode_sel = sel; addr = a; din = d; prog_n = 0;
    tick(); prog_n = 1;
  endtask

  task automatic erase_hold(input int n);
    tick(); mode_sel = 4'b1000; prog_n = 0;
    tick(n); prog_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2); #2;
    chk("R2 reset ready", {7'd0, ready}, 8'h01);
    chk("R11 reset dout", dout, 8'h00);
    tick(); rst_n = 1;
    prog_mode = 1; psen_n = 0; hv_ok = 1;

    // R8 signature
    read_at(4'b0000, 6'd48); chk("R8 sig 30h", dout, 8'h1E);
    read_at(4'b0000, 6'd49); chk("R8 sig 31h", dout, 8'h62);
    read_at(4'b0000, 6'd50); chk("R8 sig 32h", dout, 8'hFF);
    read_at(4'b0000, 6'd51); chk("R8 sig other", dout, 8'h00);

    // R1 R2 R3 byte write with polling
    pulse(4'b0111, 6'd5, 8'hA5);
    read_at(4'b0011, 6'd5);
    chk("R2 busy after start", {7'd0, ready}, 8'h00);
    chk("R3 poll value", dout, 8'h7F);
    // R4 strobe during busy
    tick(); mode_sel = 4'b0111; addr = 6'd6; din = 8'h11; prog_n = 0;
    tick(); prog_n = 1;
    read_at(4'b0011, 6'd5);
    tick(WR - 4); #2;
    chk("R2 still busy last cycle", {7'd0, ready}, 8'h00);
    tick(); #2;
    chk("R2 ready after window", {7'd0, ready}, 8'h01);
    chk("R1 R3 true data", dout, 8'hA5);
    tick(WR); read_at(4'b0011, 6'd6);
    chk("R4 ignored request", dout, 8'hFF);

    // R5 non-blank rewrite
    pulse(4'b0111, 6'd5, 8'h00);
    tick(); #2; chk("R5 no busy", {7'd0, ready}, 8'h01);
    tick(WR); read_at(4'b0011, 6'd5); chk("R5 unchanged", dout, 8'hA5);

    // R6 no programming voltage
    tick(); hv_ok = 0;
    pulse(4'b0111, 6'd7, 8'h12);
    tick(); #2; chk("R6 no busy", {7'd0, ready}, 8'h01);
    tick(WR); read_at(4'b0011, 6'd7); chk("R6 unchanged", dout, 8'hFF);
    hv_ok = 1;

    // R11 outside programming mode
    tick(); prog_mode = 0; #2; chk("R11 prog_mode low", dout, 8'h00);
    tick(); prog_mode = 1; psen_n = 1; #2; chk("R11 psen high", dout, 8'h00);
    tick(); psen_n = 0;

    // R10 lock 2 alone, then R9 lock 1
    pulse(4'b1100, 6'd0, 8'h00); tick(WR + 1);
    read_at(4'b0011, 6'd5); chk("R10 lock2 alone readable", dout, 8'hA5);
    pulse(4'b1111, 6'd0, 8'h00); tick(WR + 1);
    pulse(4'b0111, 6'd8, 8'h3C);
    tick(); #2; chk("R9 write refused", {7'd0, ready}, 8'h01);
    read_at(4'b0011, 6'd5); chk("R10 verify blocked", dout, 8'h00);
    pulse(4'b1010, 6'd0, 8'h00);
    tick(); #2; chk("R10 lock3 busy", {7'd0, ready}, 8'h00);
    tick(WR);

    // R7 erase: short hold, then full hold
    erase_hold(ER - 1); tick(2);
    read_at(4'b0000, 6'd48); read_at(4'b0011, 6'd5);
    chk("R7 short hold no erase", dout, 8'h00);
    erase_hold(ER); tick(2);
    read_at(4'b0011, 6'd5); chk("R7 erased byte", dout, 8'hFF);
    pulse(4'b0111, 6'd8, 8'h3C); tick(WR + 1);
    read_at(4'b0011, 6'd8); chk("R7 R9 unlocked write", dout, 8'h3C);
    tick(2);
    finish_run();
  end
endmodule